// File: doc/BRIEF.md
# Two-Cycle Store Pipeline Sequencer

This block is the control for a three-stage fetch, decode and execute pipeline in which every instruction except a store needs one execute cycle. A store needs two execute cycles. In the first, the effective address is formed from a base operand and an offset and captured in an address register. In the second, that register drives the bus address, the source operand is placed on the data-out bus, and the write strobe rises. During the address cycle the sequencer freezes the stages upstream. The instruction in decode stays where it is, and the word offered for fetch in that cycle is not accepted.

The fetch side supplies, in each cycle, a valid flag and a store flag for the word being fetched. The execute side supplies the base, offset and source operand values of the instruction in execute. An interrupt request is accepted only in a cycle in which a new fetch begins. When it is accepted, the sequencer raises a one-cycle take pulse and discards the instructions in fetch and decode. The instruction in execute still finishes.

Top module: `store_seq`

## Requirements
- R1: An active-low asynchronous reset empties all stages. While reset is low, and in the cycles after release until a new instruction arrives, `stall`, `addr_le`, `wr_en` and `irq_take` stay low. A store caught in the middle is abandoned and never writes.
- R2: An instruction whose store flag is 0 spends one cycle in execute. It never raises `stall`, `addr_le` or `wr_en`.
- R3: In the first execute cycle of a store, `stall` and `addr_le` are 1. The address register captures `base_val + offset_val`, truncated to AW bits.
- R4: In the cycle after the address cycle, `wr_en` is 1, `bus_addr` equals the captured address and `dout` equals `src_val`. `dout` is 0 whenever `wr_en` is 0.
- R5: While `stall` is 1, the fetch valid and store flags are ignored and the instruction in decode is held. That held instruction enters execute in the cycle after the data cycle.
- R6: With no stall, an instruction offered for fetch in cycle n is in execute in cycle n+2.
- R7: An interrupt is accepted only in a cycle with `stall` at 0. A request raised during a store's address cycle waits for the data cycle.
- R8: `irq_take` lasts one cycle and is not repeated until `irq_req` has been low for at least one cycle. On a take, the fetched and decoding instructions are discarded, so the execute stage is empty in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Word offered for fetch this cycle is an instruction |
| fetch_store | input | 1 | Offered word is a store |
| irq_req | input | 1 | Interrupt request level |
| base_val | input | AW | Base operand of the instruction in execute |
| offset_val | input | AW | Offset operand of the instruction in execute |
| src_val | input | DW | Store data operand of the instruction in execute |
| stall | output | 1 | Freeze fetch and decode this cycle |
| addr_le | output | 1 | Address register loads this cycle |
| wr_en | output | 1 | Write strobe |
| irq_take | output | 1 | Interrupt accepted this cycle |
| bus_addr | output | AW | Address register output |
| dout | output | DW | Store data bus |

## Verification
The hardest situation to reach from the ports is an interrupt request that arrives during a store's address cycle. The take must not happen there. It must happen one cycle later, while the data write is still under way, and it must discard the next store, which is waiting in decode. The stimulus sets this up by fetching two stores back to back and raising the request exactly when the first store stalls. The test then checks three things: the write completes, the take follows in the next cycle, and the second store never produces an address cycle. A second sequence holds the request high across a take to show that the pulse does not repeat.

// File: rtl/store_seq.sv
module store_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic          fetch_store,
  input  logic          irq_req,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] offset_val,
  input  logic [DW-1:0] src_val,
  output logic          stall,
  output logic          addr_le,
  output logic          wr_en,
  output logic          irq_take,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] dout
);

  logic          dec_vld, dec_st;
  logic          ex_vld, ex_st, ex_second;
  logic          irq_busy;
  logic [AW-1:0] addr_q;

  assign addr_le  = ex_vld & ex_st & ~ex_second;
  assign stall    = addr_le;
  assign wr_en    = ex_vld & ex_st & ex_second;
  assign irq_take = rst_n & irq_req & ~stall & ~irq_busy;
  assign bus_addr = addr_q;
  assign dout     = wr_en ? src_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld   <= 1'b0;
      dec_st    <= 1'b0;
      ex_vld    <= 1'b0;
      ex_st     <= 1'b0;
      ex_second <= 1'b0;
      irq_busy  <= 1'b0;
      addr_q    <= '0;
    end else begin
      if (stall) begin
        ex_second <= 1'b1;
      end else begin
        ex_vld    <= dec_vld & ~irq_take;
        ex_st     <= dec_st;
        ex_second <= 1'b0;
        dec_vld   <= fetch_valid & ~irq_take;
        dec_st    <= fetch_store;
      end
      if (addr_le) addr_q <= base_val + offset_val;
      irq_busy <= irq_take | (irq_busy & irq_req);
    end
  end

  p_write_follows_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_le |=> wr_en);
  p_addr_from_operands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_le |=> bus_addr == AW'($past(base_val) + $past(offset_val)));
  p_single_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  p_take_not_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !irq_take);
  p_take_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);
  p_take_flushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (!addr_le && !wr_en));
  p_dout_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> dout == '0);

endmodule

// File: tb/store_seq_tb.sv
module store_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0, fetch_store = 1'b0, irq_req = 1'b0;
  logic [AW-1:0] base_val = '0, offset_val = '0;
  logic [DW-1:0] src_val = '0;
  logic stall, addr_le, wr_en, irq_take;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] dout;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  store_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_store(fetch_store),
    .irq_req(irq_req), .base_val(base_val), .offset_val(offset_val), .src_val(src_val),
    .stall(stall), .addr_le(addr_le), .wr_en(wr_en), .irq_take(irq_take),
    .bus_addr(bus_addr), .dout(dout));

  // {fv, fs, irq, base, off, src, stall, ale, wr, take, addr, dout}
  localparam logic [46:0] VEC [NV] = '{
    {3'b100, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b110, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b100, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b110, 8'h10, 8'h04, 8'h00, 4'b1100, 8'h00, 8'h00},
    {3'b100, 8'h00, 8'h00, 8'h5A, 4'b0010, 8'h14, 8'h5A},
    {3'b000, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b110, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b111, 8'h00, 8'h00, 8'h00, 4'b0001, 8'h00, 8'h00},
    {3'b101, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b110, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b110, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b111, 8'h20, 8'h03, 8'h00, 4'b1100, 8'h00, 8'h00},
    {3'b001, 8'h00, 8'h00, 8'hC3, 4'b0011, 8'h23, 8'hC3},
    {3'b111, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b000, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00},
    {3'b000, 8'h40, 8'h3F, 8'h00, 4'b1100, 8'h00, 8'h00},
    {3'b000, 8'h00, 8'h00, 8'h99, 4'b0010, 8'h7F, 8'h99},
    {3'b000, 8'h00, 8'h00, 8'h00, 4'b0000, 8'h00, 8'h00}
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2, 5, 6, 17: return "R2 R6";
      3, 15:             return "R3 R5";
      4, 16:             return "R4";
      7, 8, 13, 14:      return "R8";
      9, 10:             return "R8 R6";
      11:                return "R7 R3";
      default:           return "R7 R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    fetch_valid = 1'b0; fetch_store = 1'b0; irq_req = 1'b0;
    base_val = '0; offset_val = '0; src_val = '0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", {60'd0, stall, addr_le, wr_en, irq_take}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      @(negedge clk);
      v = VEC[i];
      fetch_valid = v[46]; fetch_store = v[45]; irq_req = v[44];
      base_val = AW'(v[43:36]); offset_val = AW'(v[35:28]); src_val = DW'(v[27:20]);
      #8;
      check(req_of(i), {60'd0, stall, addr_le, wr_en, irq_take}, {60'd0, v[19:16]});
      if (v[17]) begin
        check(req_of(i), 64'(bus_addr), 64'(v[15:8]));
        check(req_of(i), 64'(dout), 64'(v[7:0]));
      end else begin
        check("R4 dout idle", 64'(dout), 64'd0);
      end
    end

    // R3 address wraps at AW bits
    @(negedge clk); idle_inputs(); fetch_valid = 1'b1; fetch_store = 1'b1;
    @(negedge clk); idle_inputs();
    @(negedge clk); base_val = 16'hFFFF; offset_val = 16'h0002;
    #8 check("R3 wrap ale", {63'd0, addr_le}, 64'd1);
    @(negedge clk); idle_inputs(); src_val = 16'hBEEF;
    #8 check("R3 wrap addr", 64'(bus_addr), 64'h0001);
    check("R4 data", 64'(dout), 64'hBEEF);

    // R1 reset in the middle of a store
    @(negedge clk); idle_inputs(); fetch_valid = 1'b1; fetch_store = 1'b1;
    @(negedge clk); idle_inputs();
    @(negedge clk);
    #4 check("R1 pre-reset stall", {63'd0, stall}, 64'd1);
    rst_n = 1'b0;
    #2 check("R1 reset clears", {60'd0, stall, addr_le, wr_en, irq_take}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #8 check("R1 no stale write", {60'd0, stall, addr_le, wr_en, irq_take}, 64'd0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule